// File: doc/BRIEF.md
# Scanline Table DMA Engine

This block moves short bursts of bytes from memory into a window of peripheral registers once per horizontal blank. Each of its eight channels walks its own list in memory. The list is a sequence of entries, and each entry starts with a line-count byte. The count says for how many display lines the entry applies, and its top bit chooses whether fresh data is fetched on every line or the same bytes are sent again. A channel may also take its data through a 16-bit pointer stored in the list, which gives an indirect mode.

Software loads each channel's settings through a narrow configuration port and then writes an enable mask. The timing generator supplies a line-start pulse and a horizontal-blank pulse, together with a flag that marks the top display line. On each blank the engine services the enabled channels in index order. It reads memory and writes the register window over two byte buses, and each bus has a ready handshake. A channel that reads a zero count turns itself off.

Top module: `line_dma_engine`

## Requirements
- R1: Writing a nonzero enable mask arms an initialisation. At the next `line_start` pulse, every channel whose bit is set gets its working list pointer loaded from its list start address, and its line counter cleared to zero.
- R2: A `hblank` pulse while `top_line` is low and the mask is nonzero starts a service pass. Enabled channels are serviced strictly in ascending index order, and disabled channels are never touched. A `hblank` pulse while `top_line` is high has no effect.
- R3: When bits 6:0 of a channel's counter are zero, a count byte is read from list_bank:list_pointer. A count of zero clears that channel's bit in `en_state`, and no register write is made for it.
- R4: When control bit 6 is set (indirect), the two bytes after the count are read as a data pointer, low byte first. The list pointer then ends three bytes past the count.
- R5: The counter is decremented before each burst. Bit 7 of the decremented value selects repeat mode (1 = fresh data every line, 0 = the same data on every line of the entry).
- R6: Data is read from indirect_bank:data_pointer in indirect mode and from list_bank:list_pointer in direct mode. Register writes go to 0x2100 + target + k, where k is the per-beat offset.
- R7: Control bits 2:0 select the burst, given as offsets per beat: 0 gives {0}; 1 gives {0,1}; 2 and 6 give {0,0}; 3 and 7 give {0,0,1,1}; 4 gives {0,1,2,3}; 5 gives {0,1,0,1}.
- R8: After a burst, the advanced read address is written back to the data pointer (indirect) or the list pointer (direct) when in repeat mode. In direct mode it is also written back when counter bits 6:0 have reached zero.
- R9: `busy` rises in the cycle after an accepted `hblank` and stays high until the pass ends. The pass ends with a single-cycle `done` pulse.
- R10: Each byte is one read and then one write. Each request is held stable until its ready is seen. Address increments wrap within 16 bits and never change the bank.

Configuration port: `cfg_sel` selects a field: 0 = control byte, 1 = target offset, 2 = list start low byte, 3 = list start high byte, 4 = list bank, 5 = indirect bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration field write strobe |
| cfg_chan | input | 3 | Channel addressed by the configuration write |
| cfg_sel | input | 3 | Field selector, encoding as listed above |
| cfg_data | input | 8 | Configuration byte |
| en_we | input | 1 | Enable mask write strobe |
| en_data | input | 8 | New enable mask, one bit per channel |
| line_start | input | 1 | Start-of-line pulse |
| hblank | input | 1 | Horizontal blank pulse |
| top_line | input | 1 | High while the first display line is current |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 24 | Memory read address, bank in bits 23:16 |
| rd_ready | input | 1 | Read accepted, `rd_data` valid |
| rd_data | input | 8 | Memory read data |
| wr_req | output | 1 | Register write request |
| wr_addr | output | 16 | Register write address |
| wr_data | output | 8 | Register write data |
| wr_ready | input | 1 | Register write accepted |
| busy | output | 1 | Service pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| en_state | output | 8 | Live enable mask, including bits cleared by the engine |

## Verification
The bench builds the engine with its default eight channels and the 0x2100 register base. This brings the full channel set into reach: the gap between enabled channels 2 and 5 in the priority pass, and every one of the eight burst codes. The bench memory answers reads and writes after latencies that change between tests, so requests must be held through wait states. It also places a list at the top of a 16-bit page so that the address wrap inside a bank can be seen on the read bus.

// File: rtl/ldma_pkg.sv
package ldma_pkg;

    localparam int ADDR_W = 16;
    localparam int BANK_W = 8;
    localparam int BYTE_W = 8;
    localparam int FULL_W = ADDR_W + BANK_W;

    typedef enum logic [2:0] {
        F_CTRL   = 3'd0,
        F_TARGET = 3'd1,
        F_LST_LO = 3'd2,
        F_LST_HI = 3'd3,
        F_LBANK  = 3'd4,
        F_IBANK  = 3'd5
    } cfg_field_e;

    typedef struct packed {
        logic [BYTE_W-1:0] ctrl;
        logic [BYTE_W-1:0] target;
        logic [BANK_W-1:0] lbank;
        logic [ADDR_W-1:0] lstart;
        logic [BANK_W-1:0] ibank;
    } chan_cfg_t;

    typedef struct packed {
        logic [ADDR_W-1:0] lptr;
        logic [ADDR_W-1:0] dptr;
        logic [BYTE_W-1:0] cnt;
    } chan_work_t;

    typedef enum logic [3:0] {
        S_IDLE, S_PICK, S_LOAD, S_CNT, S_PLO, S_PHI,
        S_DEC, S_RD, S_WR, S_WB, S_DONE
    } seq_state_e;

    // last beat index of a burst, by control bits 2:0
    function automatic logic [1:0] burst_last(input logic [2:0] m);
        case (m)
            3'd0:               return 2'd0;
            3'd1, 3'd2, 3'd6:   return 2'd1;
            default:            return 2'd3;
        endcase
    endfunction

    // register offset for a beat within a burst
    function automatic logic [1:0] burst_off(input logic [2:0] m, input logic [1:0] b);
        case (m)
            3'd1, 3'd4: return b;
            3'd3, 3'd7: return {1'b0, b[1]};
            3'd5:       return {1'b0, b[0]};
            default:    return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/ldma_chan_bank.sv
module ldma_chan_bank
    import ldma_pkg::*;
#(
    parameter int NCH = 8,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [CW-1:0]           cfg_chan,
    input  cfg_field_e              cfg_sel,
    input  logic [BYTE_W-1:0]       cfg_data,
    input  logic                    init_go,
    input  logic [NCH-1:0]          init_mask,
    input  logic                    wb_we,
    input  logic [CW-1:0]           wb_chan,
    input  chan_work_t              wb_work,
    output chan_cfg_t [NCH-1:0]     cfg_q,
    output chan_work_t [NCH-1:0]    work_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            work_q <= '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (cfg_we && cfg_chan == CW'(i)) begin
                    case (cfg_sel)
                        F_CTRL:   cfg_q[i].ctrl         <= cfg_data;
                        F_TARGET: cfg_q[i].target       <= cfg_data;
                        F_LST_LO: cfg_q[i].lstart[7:0]  <= cfg_data;
                        F_LST_HI: cfg_q[i].lstart[15:8] <= cfg_data;
                        F_LBANK:  cfg_q[i].lbank        <= cfg_data;
                        F_IBANK:  cfg_q[i].ibank        <= cfg_data;
                        default:  ;
                    endcase
                end
                if (wb_we && wb_chan == CW'(i))
                    work_q[i] <= wb_work;
                if (init_go && init_mask[i]) begin
                    work_q[i].lptr <= cfg_q[i].lstart;
                    work_q[i].cnt  <= '0;
                end
            end
        end
    end

    assert_init_clears_R1: assert property (@(posedge clk) disable iff (rst)
        (init_go && init_mask[0]) |=> (work_q[0].cnt == '0 && work_q[0].lptr == $past(cfg_q[0].lstart)));

endmodule

// File: rtl/ldma_pick.sv
module ldma_pick #(
    parameter int NCH = 8,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] mask,
    input  logic [CW:0]    from,
    output logic           found,
    output logic [CW-1:0]  idx
);

    // lowest enabled channel at or above 'from'
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i] && (CW+1)'(i) >= from) begin
                found = 1'b1;
                idx   = CW'(i);
            end
        end
    end

endmodule

// File: rtl/ldma_seq.sv
module ldma_seq
    import ldma_pkg::*;
#(
    parameter int NCH = 8,
    parameter logic [ADDR_W-1:0] REG_BASE = 16'h2100,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en_we,
    input  logic [NCH-1:0]          en_data,
    input  logic                    line_start,
    input  logic                    hblank,
    input  logic                    top_line,
    input  chan_cfg_t [NCH-1:0]     cfg_q,
    input  chan_work_t [NCH-1:0]    work_q,
    input  logic                    pick_found,
    input  logic [CW-1:0]           pick_idx,
    output logic [CW:0]             pick_from,
    output logic                    init_go,
    output logic                    wb_we,
    output logic [CW-1:0]           wb_chan,
    output chan_work_t              wb_work,
    output logic                    rd_req,
    output logic [FULL_W-1:0]       rd_addr,
    input  logic                    rd_ready,
    input  logic [BYTE_W-1:0]       rd_data,
    output logic                    wr_req,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [BYTE_W-1:0]       wr_data,
    input  logic                    wr_ready,
    output logic                    busy,
    output logic                    done,
    output logic [NCH-1:0]          en_state
);

    seq_state_e          st;
    logic [NCH-1:0]      mask;
    logic                pend;
    logic [CW-1:0]       ch;
    logic [CW:0]         cur;
    logic [ADDR_W-1:0]   lp, dp, ra;
    logic [BYTE_W-1:0]   cnt, dbuf;
    logic                rep;
    logic [1:0]          beat;

    chan_cfg_t           cc;
    logic                ind;
    logic [2:0]          mode;
    logic [BYTE_W-1:0]   cnt_dec;
    logic                unused_bits;

    assign cc          = cfg_q[ch];
    assign ind         = cc.ctrl[6];
    assign mode        = cc.ctrl[2:0];
    assign cnt_dec     = cnt - 8'd1;
    assign unused_bits = ^{cc.ctrl[7], cc.ctrl[5:3], cc.lstart};

    assign init_go   = line_start && pend;
    assign pick_from = cur;
    assign wb_we     = (st == S_WB);
    assign wb_chan   = ch;
    assign wb_work   = '{lptr: lp, dptr: dp, cnt: cnt};

    assign rd_req  = (st == S_CNT) || (st == S_PLO) || (st == S_PHI) || (st == S_RD);
    assign rd_addr = (st == S_RD) ? {(ind ? cc.ibank : cc.lbank), ra} : {cc.lbank, lp};
    assign wr_req  = (st == S_WR);
    assign wr_addr = REG_BASE + {8'h00, cc.target} + ADDR_W'(burst_off(mode, beat));
    assign wr_data = dbuf;
    assign busy     = (st != S_IDLE);
    assign done     = (st == S_DONE);
    assign en_state = mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_IDLE;
            mask <= '0;
            pend <= 1'b0;
            ch   <= '0;
            cur  <= '0;
            lp   <= '0;
            dp   <= '0;
            ra   <= '0;
            cnt  <= '0;
            dbuf <= '0;
            rep  <= 1'b0;
            beat <= '0;
        end else begin
            if (init_go) pend <= 1'b0;
            case (st)
                S_IDLE: if (hblank && !top_line && |mask) begin
                    cur <= '0;
                    st  <= S_PICK;
                end
                S_PICK: if (pick_found) begin
                    ch <= pick_idx;
                    st <= S_LOAD;
                end else begin
                    st <= S_DONE;
                end
                S_LOAD: begin
                    lp  <= work_q[ch].lptr;
                    dp  <= work_q[ch].dptr;
                    cnt <= work_q[ch].cnt;
                    st  <= (work_q[ch].cnt[6:0] == '0) ? S_CNT : S_DEC;
                end
                S_CNT: if (rd_ready) begin
                    if (rd_data == '0) begin
                        cnt      <= '0;
                        mask[ch] <= 1'b0;
                        st       <= S_WB;
                    end else begin
                        cnt <= rd_data;
                        lp  <= lp + 1'b1;
                        st  <= ind ? S_PLO : S_DEC;
                    end
                end
                S_PLO: if (rd_ready) begin
                    dp[7:0] <= rd_data;
                    lp      <= lp + 1'b1;
                    st      <= S_PHI;
                end
                S_PHI: if (rd_ready) begin
                    dp[15:8] <= rd_data;
                    lp       <= lp + 1'b1;
                    st       <= S_DEC;
                end
                S_DEC: begin
                    cnt  <= cnt_dec;
                    rep  <= cnt_dec[7];
                    ra   <= ind ? dp : lp;
                    beat <= '0;
                    st   <= S_RD;
                end
                S_RD: if (rd_ready) begin
                    dbuf <= rd_data;
                    ra   <= ra + 1'b1;
                    st   <= S_WR;
                end
                S_WR: if (wr_ready) begin
                    if (beat == burst_last(mode)) begin
                        if (rep && ind) dp <= ra;
                        if (!ind && (rep || cnt[6:0] == '0)) lp <= ra;
                        st <= S_WB;
                    end else begin
                        beat <= beat + 1'b1;
                        st   <= S_RD;
                    end
                end
                S_WB: begin
                    cur <= (CW+1)'(ch) + 1'b1;
                    st  <= S_PICK;
                end
                S_DONE: st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
            if (en_we) begin
                mask <= en_data;
                if (|en_data) pend <= 1'b1;
            end
        end
    end

    assert_bus_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && wr_req));
    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr)));
    assert_wr_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_ready) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));
    assert_wr_after_rd_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_req) |-> $past(rd_req && rd_ready));
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!rd_req && !wr_req));
    assert_zero_disables_R3: assert property (@(posedge clk) disable iff (rst)
        (st == S_CNT && rd_ready && rd_data == '0 && !en_we) |=> !en_state[$past(ch)]);
    assert_dest_window_R6: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> ((wr_addr - REG_BASE) < 16'd259));

endmodule

// File: rtl/line_dma_engine.sv
module line_dma_engine
    import ldma_pkg::*;
#(
    parameter int NCH = 8,
    parameter logic [15:0] REG_BASE = 16'h2100,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CW-1:0]     cfg_chan,
    input  logic [2:0]        cfg_sel,
    input  logic [7:0]        cfg_data,
    input  logic              en_we,
    input  logic [NCH-1:0]    en_data,
    input  logic              line_start,
    input  logic              hblank,
    input  logic              top_line,
    output logic              rd_req,
    output logic [23:0]       rd_addr,
    input  logic              rd_ready,
    input  logic [7:0]        rd_data,
    output logic              wr_req,
    output logic [15:0]       wr_addr,
    output logic [7:0]        wr_data,
    input  logic              wr_ready,
    output logic              busy,
    output logic              done,
    output logic [NCH-1:0]    en_state
);

    chan_cfg_t  [NCH-1:0] cfg_q;
    chan_work_t [NCH-1:0] work_q;
    logic                 init_go, wb_we, pick_found;
    logic [CW-1:0]        wb_chan, pick_idx;
    logic [CW:0]          pick_from;
    chan_work_t           wb_work;

    ldma_chan_bank #(.NCH(NCH)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_chan  (cfg_chan),
        .cfg_sel   (cfg_field_e'(cfg_sel)),
        .cfg_data  (cfg_data),
        .init_go   (init_go),
        .init_mask (en_state),
        .wb_we     (wb_we),
        .wb_chan   (wb_chan),
        .wb_work   (wb_work),
        .cfg_q     (cfg_q),
        .work_q    (work_q)
    );

    ldma_pick #(.NCH(NCH)) u_pick (
        .mask  (en_state),
        .from  (pick_from),
        .found (pick_found),
        .idx   (pick_idx)
    );

    ldma_seq #(.NCH(NCH), .REG_BASE(REG_BASE)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .en_we      (en_we),
        .en_data    (en_data),
        .line_start (line_start),
        .hblank     (hblank),
        .top_line   (top_line),
        .cfg_q      (cfg_q),
        .work_q     (work_q),
        .pick_found (pick_found),
        .pick_idx   (pick_idx),
        .pick_from  (pick_from),
        .init_go    (init_go),
        .wb_we      (wb_we),
        .wb_chan    (wb_chan),
        .wb_work    (wb_work),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .rd_ready   (rd_ready),
        .rd_data    (rd_data),
        .wr_req     (wr_req),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_ready   (wr_ready),
        .busy       (busy),
        .done       (done),
        .en_state   (en_state)
    );

endmodule

// File: tb/line_dma_engine_test.sv
`timescale 1ns/1ps
module line_dma_engine_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_chan = '0;
    logic [2:0]  cfg_sel = '0;
    logic [7:0]  cfg_data = '0;
    logic        en_we = 1'b0;
    logic [7:0]  en_data = '0;
    logic        line_start = 1'b0;
    logic        hblank = 1'b0;
    logic        top_line = 1'b0;
    logic        rd_req, wr_req, busy, done;
    logic [23:0] rd_addr;
    logic        rd_ready = 1'b0;
    logic [7:0]  rd_data = '0;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data;
    logic        wr_ready = 1'b0;
    logic [7:0]  en_state;

    always #2 clk = ~clk;

    line_dma_engine uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .en_we(en_we), .en_data(en_data), .line_start(line_start),
        .hblank(hblank), .top_line(top_line), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ready(rd_ready), .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_ready(wr_ready), .busy(busy), .done(done), .en_state(en_state)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0]  mem [logic [23:0]];
    logic [23:0] rd_log [$];
    logic [15:0] wa_log [$];
    logic [7:0]  wd_log [$];
    int rd_lat = 0, wr_lat = 0, rcnt = 0, wcnt = 0;
    int done_cnt = 0;
    bit busy_seen = 0;

    // memory and register-window responders
    always @(negedge clk) begin
        if (rd_ready) begin
            rd_ready = 1'b0;
            rcnt = 0;
        end else if (rd_req === 1'b1) begin
            if (rcnt >= rd_lat) begin
                rd_ready = 1'b1;
                rd_data = mem.exists(rd_addr) ? mem[rd_addr] : 8'h00;
                rd_log.push_back(rd_addr);
            end else rcnt++;
        end
        if (wr_ready) begin
            wr_ready = 1'b0;
            wcnt = 0;
        end else if (wr_req === 1'b1) begin
            if (wcnt >= wr_lat) begin
                wr_ready = 1'b1;
                wa_log.push_back(wr_addr);
                wd_log.push_back(wr_data);
            end else wcnt++;
        end
    end

    always @(posedge clk) begin
        if (done === 1'b1) done_cnt++;
        if (busy === 1'b1) busy_seen = 1;
    end

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic cfg(input int ch, input int sel, input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_chan = 3'(ch); cfg_sel = 3'(sel); cfg_data = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input int ch, input logic [7:0] ctrl, input logic [7:0] tgt,
                         input logic [7:0] lbank, input logic [15:0] lstart, input logic [7:0] ibank);
        cfg(ch, 0, ctrl);
        cfg(ch, 1, tgt);
        cfg(ch, 2, lstart[7:0]);
        cfg(ch, 3, lstart[15:8]);
        cfg(ch, 4, lbank);
        cfg(ch, 5, ibank);
    endtask

    task automatic enable(input logic [7:0] m);
        @(negedge clk);
        en_we = 1'b1; en_data = m;
        @(negedge clk);
        en_we = 1'b0;
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    task automatic clear_logs();
        rd_log.delete();
        wa_log.delete();
        wd_log.delete();
    endtask

    task automatic run_line(input bit chk_busy);
        int d0 = done_cnt;
        int g = 0;
        clear_logs();
        @(negedge clk);
        hblank = 1'b1;
        @(negedge clk);
        hblank = 1'b0;
        if (chk_busy) check(busy === 1'b1, "R9 busy after hblank", 32'(busy), 1);
        while (done_cnt == d0 && g < 3000) begin
            @(negedge clk);
            g++;
        end
        @(negedge clk);
        if (chk_busy) begin
            check(done_cnt == d0 + 1, "R9 single done pulse", done_cnt - d0, 1);
            check(busy === 1'b0, "R9 busy low after done", 32'(busy), 0);
        end
    endtask

    task automatic t_reset();
        check(busy === 1'b0 && done === 1'b0, "R9 reset idle", {busy, done}, 0);
        check(rd_req === 1'b0 && wr_req === 1'b0, "R10 reset no requests", {rd_req, wr_req}, 0);
        check(en_state === 8'h00, "R3 reset mask", en_state, 0);
    endtask

    // R7 R6 R5: every burst code, direct mode, count of one
    task automatic t_bursts();
        for (int m = 0; m < 8; m++) begin
            int n;
            int offs [4];
            case (m)
                0: begin n = 1; offs = '{0, 0, 0, 0}; end
                1: begin n = 2; offs = '{0, 1, 0, 0}; end
                2, 6: begin n = 2; offs = '{0, 0, 0, 0}; end
                3, 7: begin n = 4; offs = '{0, 0, 1, 1}; end
                4: begin n = 4; offs = '{0, 1, 2, 3}; end
                default: begin n = 4; offs = '{0, 1, 0, 1}; end
            endcase
            mem.delete();
            mem[24'h011000] = 8'h01;
            for (int k = 0; k < 4; k++) mem[24'h011001 + 24'(k)] = 8'hA0 + 8'(k);
            rd_lat = m % 3;
            wr_lat = m % 2;
            setup(0, 8'(m), 8'h18, 8'h01, 16'h1000, 8'h00);
            enable(8'h01);
            run_line(m == 0);
            check(wa_log.size() == n, "R7 burst length", wa_log.size(), n);
            for (int k = 0; k < n && k < wa_log.size(); k++) begin
                check(wa_log[k] == 16'h2118 + 16'(offs[k]), "R7 burst register", wa_log[k], 16'h2118 + 16'(offs[k]));
                check(wd_log[k] == 8'hA0 + 8'(k), "R6 source byte", wd_log[k], 8'hA0 + 8'(k));
            end
            check(rd_log.size() > 0 && rd_log[0] == 24'h011000, "R3 count fetched first", rd_log[0], 24'h011000);
            check(en_state == 8'h01, "R3 nonzero count keeps channel", en_state, 8'h01);
        end
    endtask

    task automatic t_zero_count();
        mem.delete();
        setup(0, 8'h00, 8'h18, 8'h01, 16'h2000, 8'h00);
        enable(8'h01);
        run_line(0);
        check(wa_log.size() == 0, "R3 zero count no write", wa_log.size(), 0);
        check(rd_log.size() == 1 && rd_log[0] == 24'h012000, "R3 one count read", rd_log.size(), 1);
        check(en_state == 8'h00, "R3 zero count clears enable", en_state, 0);
    endtask

    task automatic t_repeat();
        mem.delete();
        mem[24'h017000] = 8'h83;
        mem[24'h017001] = 8'hD0;
        mem[24'h017002] = 8'hD1;
        mem[24'h017003] = 8'hD2;
        setup(0, 8'h00, 8'h20, 8'h01, 16'h7000, 8'h00);
        enable(8'h01);
        for (int l = 0; l < 3; l++) begin
            run_line(0);
            check(wd_log.size() == 1 && wd_log[0] == 8'hD0 + 8'(l), "R5 repeat fresh byte", wd_log[0], 8'hD0 + 8'(l));
        end
        run_line(0);
        check(rd_log.size() == 1 && rd_log[0] == 24'h017004, "R8 pointer stored after repeat", rd_log[0], 24'h017004);
        check(en_state == 8'h00 && wa_log.size() == 0, "R3 end of list", en_state, 0);
    endtask

    task automatic t_hold();
        mem.delete();
        mem[24'h018000] = 8'h03;
        mem[24'h018001] = 8'hE0;
        mem[24'h018002] = 8'h01;
        mem[24'h018003] = 8'hE5;
        setup(0, 8'h00, 8'h21, 8'h01, 16'h8000, 8'h00);
        enable(8'h01);
        for (int l = 0; l < 3; l++) begin
            run_line(0);
            check(wd_log.size() == 1 && wd_log[0] == 8'hE0, "R5 non-repeat same byte", wd_log[0], 8'hE0);
        end
        run_line(0);
        check(rd_log.size() > 0 && rd_log[0] == 24'h018002, "R8 direct store at count end", rd_log[0], 24'h018002);
        check(wd_log.size() == 1 && wd_log[0] == 8'hE5, "R8 next entry data", wd_log[0], 8'hE5);
        // re-arm: list restarts from the start address
        enable(8'h01);
        run_line(0);
        check(wd_log.size() == 1 && wd_log[0] == 8'hE0, "R1 reinit restarts list", wd_log[0], 8'hE0);
        check(rd_log.size() > 0 && rd_log[0] == 24'h018000, "R1 count read at start", rd_log[0], 24'h018000);
    endtask

    task automatic t_indirect();
        mem.delete();
        mem[24'h016000] = 8'h01;
        mem[24'h016001] = 8'h34;
        mem[24'h016002] = 8'h12;
        mem[24'h021234] = 8'h55;
        mem[24'h021235] = 8'h66;
        rd_lat = 1;
        wr_lat = 2;
        setup(1, 8'h41, 8'h40, 8'h01, 16'h6000, 8'h02);
        enable(8'h02);
        run_line(0);
        check(rd_log.size() == 5, "R4 read count", rd_log.size(), 5);
        if (rd_log.size() == 5) begin
            check(rd_log[1] == 24'h016001 && rd_log[2] == 24'h016002, "R4 pointer bytes", rd_log[2], 24'h016002);
            check(rd_log[3] == 24'h021234 && rd_log[4] == 24'h021235, "R6 indirect source", rd_log[3], 24'h021234);
        end
        check(wa_log.size() == 2 && wa_log[0] == 16'h2140 && wa_log[1] == 16'h2141, "R6 destination", wa_log[1], 16'h2141);
        check(wd_log.size() == 2 && wd_log[0] == 8'h55 && wd_log[1] == 8'h66, "R4 little endian data", {wd_log[0], wd_log[1]}, 16'h5566);
        run_line(0);
        check(rd_log.size() == 1 && rd_log[0] == 24'h016003, "R4 list pointer past three", rd_log[0], 24'h016003);
        check(en_state == 8'h00, "R3 indirect channel ends", en_state, 0);
    endtask

    task automatic t_priority();
        mem.delete();
        mem[24'h013000] = 8'h01;
        mem[24'h013001] = 8'h22;
        mem[24'h014000] = 8'h01;
        mem[24'h014001] = 8'h55;
        mem[24'h015000] = 8'h01;
        mem[24'h015001] = 8'h99;
        rd_lat = 0;
        wr_lat = 0;
        setup(5, 8'h00, 8'h20, 8'h01, 16'h4000, 8'h00);
        setup(3, 8'h00, 8'h30, 8'h01, 16'h5000, 8'h00);
        setup(2, 8'h00, 8'h10, 8'h01, 16'h3000, 8'h00);
        enable(8'h24);
        run_line(1);
        check(wa_log.size() == 2, "R2 only enabled channels", wa_log.size(), 2);
        if (wa_log.size() == 2) begin
            check(wa_log[0] == 16'h2110 && wd_log[0] == 8'h22, "R2 channel 2 first", wa_log[0], 16'h2110);
            check(wa_log[1] == 16'h2120 && wd_log[1] == 8'h55, "R2 channel 5 second", wa_log[1], 16'h2120);
        end
        // top line: hblank has no effect
        top_line = 1'b1;
        busy_seen = 0;
        clear_logs();
        @(negedge clk);
        hblank = 1'b1;
        @(negedge clk);
        hblank = 1'b0;
        repeat (20) @(negedge clk);
        check(!busy_seen && rd_log.size() == 0, "R2 top line ignored", rd_log.size(), 0);
        top_line = 1'b0;
    endtask

    task automatic t_wrap();
        mem.delete();
        mem[24'h03FFFE] = 8'h01;
        mem[24'h03FFFF] = 8'h77;
        mem[24'h030000] = 8'h78;
        rd_lat = 2;
        setup(4, 8'h01, 8'h50, 8'h03, 16'hFFFE, 8'h00);
        enable(8'h10);
        run_line(0);
        check(rd_log.size() == 3 && rd_log[2] == 24'h030000, "R10 wrap keeps bank", rd_log[2], 24'h030000);
        check(wd_log.size() == 2 && wd_log[1] == 8'h78, "R10 wrapped data", wd_log[1], 8'h78);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_bursts();
        t_zero_count();
        t_repeat();
        t_hold();
        t_indirect();
        t_priority();
        t_wrap();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R9 watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule